// File: doc/BRIEF.md
# Two-Level Prefetch Address Engine

This block sits between an instruction extractor and the L1 data cache. The extractor pushes memory instructions that were picked out for early prefetching. Each pushed entry carries a base register index, a 16-bit immediate, a load/store flag and a priority bit. The engine keeps one queue for critical-path work and one for everything else. It serves one entry at a time, in order. For each entry it reads the base register, forms the line address and raises a prefetch request toward L1.

The request stays up until L1 either accepts it or squashes it because the line is already resident. The engine then takes the next queued entry. A request already in flight is never displaced by a later high-priority arrival. The engine has no register write port and no store-data path, so a wrong address from a speculative operand can only cost one useless prefetch. Per-level counters of issued and squashed prefetches are kept at the outputs.

Top module: `pfx_engine`

## Requirements
- R1: While reset is low and on the first cycle after it, `pf_req_valid` is 0, `push_ready` is 1, and all four counters are 0.
- R2: The request address is the base register value plus the sign-extended 16-bit immediate, with bits [4:0] forced to zero (32-byte lines). The base value is the `rf_rd_data` returned for the index on `rf_rd_idx` in the cycle the entry is taken.
- R3: `push_high`=1 selects the high queue and 0 the low queue. Each queue holds 4 entries in FIFO order. `push_ready` is 0 exactly when the queue chosen by `push_high` holds 4 entries, and a push is taken only when `push_valid` and `push_ready` are both 1.
- R4: When the engine is free and both queues hold entries, the next request comes from the high queue. `pf_req_high` is 1 for high-queue requests and 0 for low-queue requests.
- R5: While `pf_req_valid` is 1 and neither `pf_ack` nor `pf_squash` is 1, the request stays up with the same address, priority and store flag in the next cycle, whatever is pushed meanwhile.
- R6: After a cycle with `pf_req_valid` and either `pf_ack` or `pf_squash`, `pf_req_valid` is 0 in the next cycle. The cycle after that, the engine raises the next request if any entry was queued.
- R7: `pf_req_store` carries the store flag of the entry. No port writes register or memory data.
- R8: A reply with `pf_squash`=1 adds one to the squash counter of the request's level. A reply with only `pf_ack`=1 adds one to the issue counter of that level.
- R9: While both queues are empty and no request is in flight, no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Extractor offers an entry |
| push_ready | output | 1 | Queue selected by push_high has room |
| push_high | input | 1 | 1 = critical-path (high) queue |
| push_store | input | 1 | Entry is a store (1) or a load (0) |
| push_base | input | 5 | Base register index |
| push_imm | input | 16 | Signed displacement |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_data | input | 32 | Register value for rf_rd_idx, same cycle |
| pf_req_valid | output | 1 | Prefetch request pending |
| pf_req_addr | output | 32 | Line-aligned prefetch address |
| pf_req_high | output | 1 | Request came from the high queue |
| pf_req_store | output | 1 | Request belongs to a store |
| pf_ack | input | 1 | L1 accepted the request |
| pf_squash | input | 1 | L1 dropped the request (line present) |
| cnt_issue_hi | output | 16 | High-level prefetches accepted |
| cnt_issue_lo | output | 16 | Low-level prefetches accepted |
| cnt_squash_hi | output | 16 | High-level prefetches squashed |
| cnt_squash_lo | output | 16 | Low-level prefetches squashed |

## Verification
The bench stalls L1 on a low-priority request and then pushes high entries. This catches an engine that preempts: it would change the address or priority of the pending request in mid-stall. The bench fills both queues to four and pushes once more, so a wrong full test would either drop an entry or let it overwrite a queued one, and the order check would then fail. Negative displacements and wrapping sums check that the sign extension and the line masking are right. A random mix of accepts, squashes and stalls checks two things: that a freed engine takes the next entry one cycle after it goes idle, without waiting longer, and that each reply lands in the counter of its own level and kind.

// File: rtl/pfx_pkg.sv
// Shared constants and types for the two-level prefetch address engine.
// Assumes a 32-bit address space, 32 architectural registers and 32-byte lines.
package pfx_pkg;
    localparam int ADDR_W     = 32;
    localparam int REG_W      = 5;
    localparam int IMM_W      = 16;
    localparam int LINE_BYTES = 32;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int QDEPTH     = 4;
    localparam int LEVELS     = 2;   // index 1 = high, index 0 = low

    typedef struct packed {
        logic             is_store;
        logic [REG_W-1:0] base;
        logic [IMM_W-1:0] imm;
    } pf_entry_t;

    localparam int ENTRY_W = $bits(pf_entry_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } eng_state_t;
endpackage

// File: rtl/pfx_fifo.sv
// Small synchronous FIFO holding queued prefetch entries of one priority level.
// Assumes the caller never pushes when full nor pops when empty; the head is
// visible combinationally on dout.
module pfx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pfx_arbiter.sv
// Non-preemptive two-level selector: picks an entry only when the engine is
// free, and prefers the high queue whenever it holds something.
module pfx_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic free,
    input  logic has_hi,
    input  logic has_lo,
    output logic take_hi,
    output logic take_lo
);
    // Fixed-priority choice gated by engine availability.
    always_comb begin
        take_hi = free && has_hi;
        take_lo = free && !has_hi && has_lo;
    end

    a_r4_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        take_lo |-> !has_hi);
    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_hi, take_lo}));
endmodule

// File: rtl/pfx_addr_gen.sv
// Effective address former: base plus sign-extended displacement, rounded
// down to the start of its cache line. Purely combinational.
module pfx_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] line_addr
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] sum;

    // Sign extension, add, line alignment.
    always_comb begin
        disp      = {{(ADDR_W - IMM_W){imm[IMM_W-1]}}, imm};
        sum       = base + disp;
        line_addr = sum & LINE_MASK;
    end
endmodule

// File: rtl/pfx_engine.sv
// Two-level prefetch address engine. Queues extracted memory instructions by
// priority, takes one at a time when idle, reads its base register, forms the
// line address and holds a prefetch request until L1 accepts or squashes it.
// Assumes rf_rd_data answers rf_rd_idx in the same cycle. Writes no
// architected state.
module pfx_engine
    import pfx_pkg::*;
#(
    parameter int DEPTH = QDEPTH,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic              push_high,
    input  logic              push_store,
    input  logic [REG_W-1:0]  push_base,
    input  logic [IMM_W-1:0]  push_imm,
    output logic [REG_W-1:0]  rf_rd_idx,
    input  logic [ADDR_W-1:0] rf_rd_data,
    output logic              pf_req_valid,
    output logic [ADDR_W-1:0] pf_req_addr,
    output logic              pf_req_high,
    output logic              pf_req_store,
    input  logic              pf_ack,
    input  logic              pf_squash,
    output logic [CNT_W-1:0]  cnt_issue_hi,
    output logic [CNT_W-1:0]  cnt_issue_lo,
    output logic [CNT_W-1:0]  cnt_squash_hi,
    output logic [CNT_W-1:0]  cnt_squash_lo
);
    eng_state_t        state;
    pf_entry_t         new_ent;
    pf_entry_t         q_dout [LEVELS];
    logic [LEVELS-1:0] q_empty;
    logic [LEVELS-1:0] q_full;
    logic [LEVELS-1:0] q_push;
    logic [LEVELS-1:0] q_pop;
    logic              take_hi;
    logic              take_lo;
    logic              take_any;
    pf_entry_t         sel;
    logic [ADDR_W-1:0] line_addr;
    logic              reply;
    logic [CNT_W-1:0]  n_iss [LEVELS];
    logic [CNT_W-1:0]  n_sq  [LEVELS];

    // Incoming entry packing and backpressure for the addressed level.
    always_comb begin
        new_ent    = '{is_store: push_store, base: push_base, imm: push_imm};
        push_ready = push_high ? !q_full[1] : !q_full[0];
    end

    assign reply        = pf_req_valid && (pf_ack || pf_squash);
    assign pf_req_valid = (state == ST_WAIT);
    assign take_any     = take_hi || take_lo;
    assign q_pop        = {take_hi, take_lo};
    assign sel          = take_hi ? q_dout[1] : q_dout[0];
    assign rf_rd_idx    = sel.base;

    pfx_arbiter i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .free    (state == ST_IDLE),
        .has_hi  (!q_empty[1]),
        .has_lo  (!q_empty[0]),
        .take_hi (take_hi),
        .take_lo (take_lo)
    );

    pfx_addr_gen #(
        .ADDR_W     (ADDR_W),
        .IMM_W      (IMM_W),
        .LINE_BYTES (LINE_BYTES)
    ) i_agen (
        .base      (rf_rd_data),
        .imm       (sel.imm),
        .line_addr (line_addr)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign q_push[l] = push_valid && push_ready && (push_high == (l == 1));

        pfx_fifo #(
            .W     (ENTRY_W),
            .DEPTH (DEPTH)
        ) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[l]),
            .din   (new_ent),
            .pop   (q_pop[l]),
            .dout  (q_dout[l]),
            .empty (q_empty[l]),
            .full  (q_full[l])
        );

        // Per-level reply counters; squash wins over accept.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                n_iss[l] <= '0;
                n_sq[l]  <= '0;
            end else if (reply && (pf_req_high == (l == 1))) begin
                if (pf_squash) n_sq[l]  <= n_sq[l] + 1'b1;
                else           n_iss[l] <= n_iss[l] + 1'b1;
            end
        end
    end

    assign cnt_issue_hi  = n_iss[1];
    assign cnt_issue_lo  = n_iss[0];
    assign cnt_squash_hi = n_sq[1];
    assign cnt_squash_lo = n_sq[0];

    // Engine sequencing: latch a request when an entry is taken, release on reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            pf_req_addr  <= '0;
            pf_req_high  <= 1'b0;
            pf_req_store <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (take_any) begin
                state        <= ST_WAIT;
                pf_req_addr  <= line_addr;
                pf_req_high  <= take_hi;
                pf_req_store <= sel.is_store;
            end
        end else if (reply) begin
            state <= ST_IDLE;
        end
    end

    a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_valid && !pf_ack && !pf_squash |=>
            pf_req_valid && $stable(pf_req_addr) && $stable(pf_req_high) && $stable(pf_req_store));
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        reply |=> !pf_req_valid);
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_valid |-> (pf_req_addr[OFF_W-1:0] == '0));
    a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_req_valid && (&q_empty) |=> !pf_req_valid);
    a_r8_squash_hi_count: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_valid && pf_squash && pf_req_high |=> cnt_squash_hi == $past(cnt_squash_hi) + 1'b1);
    a_r8_issue_lo_count: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_valid && pf_ack && !pf_squash && !pf_req_high |=> cnt_issue_lo == $past(cnt_issue_lo) + 1'b1);
endmodule

// File: tb/test_pfx_engine.sv
`timescale 1ns/1ps
module test_pfx_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic        push_high = 1'b0;
    logic        push_store = 1'b0;
    logic [4:0]  push_base = '0;
    logic [15:0] push_imm = '0;
    logic [4:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        pf_req_valid;
    logic [31:0] pf_req_addr;
    logic        pf_req_high;
    logic        pf_req_store;
    logic        pf_ack = 1'b0;
    logic        pf_squash = 1'b0;
    logic [15:0] cnt_issue_hi, cnt_issue_lo, cnt_squash_hi, cnt_squash_lo;

    int n_chk = 0;
    int n_err = 0;

    // model state
    logic [21:0] mq_hi[$];
    logic [21:0] mq_lo[$];
    bit          prev_valid = 0;
    bit          prev_reply = 0;
    logic [31:0] prev_addr;
    bit          prev_high, prev_store;
    bit          pend_push = 0;
    bit          pend_high;
    logic [21:0] pend_ent;
    int          e_iss_hi = 0, e_iss_lo = 0, e_sq_hi = 0, e_sq_lo = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] rf_val(input logic [4:0] idx);
        return 32'h9E37_79B9 * ({27'd0, idx} + 32'd1);
    endfunction

    function automatic logic [31:0] exp_line(input logic [4:0] b, input logic [15:0] im);
        return (rf_val(b) + {{16{im[15]}}, im}) & ~32'h1F;
    endfunction

    assign rf_rd_data = rf_val(rf_rd_idx);

    pfx_engine i_pfx_engine (
        .clk, .rst_n, .push_valid, .push_ready, .push_high, .push_store,
        .push_base, .push_imm, .rf_rd_idx, .rf_rd_data, .pf_req_valid,
        .pf_req_addr, .pf_req_high, .pf_req_store, .pf_ack, .pf_squash,
        .cnt_issue_hi, .cnt_issue_lo, .cnt_squash_hi, .cnt_squash_lo
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive inputs after a falling edge, then observe at the next falling edge.
    task automatic cyc(input bit pv, input bit ph, input bit ps, input logic [4:0] b,
                       input logic [15:0] im, input bit ak, input bit sq);
        logic [21:0] e;
        bit          eh;
        push_valid = pv; push_high = ph; push_store = ps; push_base = b; push_imm = im;
        pf_ack = ak; pf_squash = sq;
        #1;
        if (pv)  // R3 backpressure follows occupancy of the chosen queue
            chk(push_ready == ((ph ? mq_hi.size() : mq_lo.size()) < 4), "R3 push_ready",
                32'(push_ready), 32'((ph ? mq_hi.size() : mq_lo.size()) < 4));
        pend_push = pv && push_ready;
        pend_ent  = {ps, b, im};
        pend_high = ph;
        prev_reply = pf_req_valid && (ak || sq);
        if (prev_reply) begin
            if (sq) begin if (pf_req_high) e_sq_hi++; else e_sq_lo++; end
            else    begin if (pf_req_high) e_iss_hi++; else e_iss_lo++; end
        end
        @(negedge clk);
        if (pf_req_valid && !prev_valid) begin
            if (mq_hi.size() > 0)      begin e = mq_hi.pop_front(); eh = 1; end
            else if (mq_lo.size() > 0) begin e = mq_lo.pop_front(); eh = 0; end
            else begin e = '0; eh = 0; chk(0, "R9 request with empty queues", 1, 0); end
            chk(pf_req_addr == exp_line(e[20:16], e[15:0]), "R2 address", pf_req_addr, exp_line(e[20:16], e[15:0]));
            chk(pf_req_high == eh, "R4 level chosen", 32'(pf_req_high), 32'(eh));
            chk(pf_req_store == e[21], "R7 store flag", 32'(pf_req_store), 32'(e[21]));
        end else if (pf_req_valid && prev_valid) begin
            chk(!prev_reply, "R6 request kept after reply", 1, 0);
            chk(pf_req_addr == prev_addr && pf_req_high == prev_high && pf_req_store == prev_store,
                "R5 request changed while stalled", pf_req_addr, prev_addr);
        end else if (!pf_req_valid && !prev_valid) begin
            chk(mq_hi.size() == 0 && mq_lo.size() == 0, "R6 idle engine left entry queued",
                32'(mq_hi.size() + mq_lo.size()), 0);
        end
        if (prev_reply) chk(!pf_req_valid, "R6 valid after reply", 32'(pf_req_valid), 0);
        if (pend_push) begin
            if (pend_high) mq_hi.push_back(pend_ent); else mq_lo.push_back(pend_ent);
        end
        prev_valid = pf_req_valid; prev_addr = pf_req_addr;
        prev_high = pf_req_high;   prev_store = pf_req_store;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h00C0_FFEE);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pf_req_valid == 0, "R1 valid in reset", 32'(pf_req_valid), 0);
        chk(push_ready == 1, "R1 ready in reset", 32'(push_ready), 1);
        chk({cnt_issue_hi, cnt_issue_lo, cnt_squash_hi, cnt_squash_lo} == '0, "R1 counters in reset",
            32'(cnt_issue_hi + cnt_issue_lo + cnt_squash_hi + cnt_squash_lo), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pf_req_valid == 0, "R1 valid after reset", 32'(pf_req_valid), 0);

        // Directed: low store with negative displacement, L1 stalled (R2, R7)
        cyc(1, 0, 1, 5'd3, 16'h8000, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R5: high pushes while the low request waits; then fill both queues past 4 (R3)
        for (int i = 0; i < 5; i++) cyc(1, 1, i[0], 5'(i + 7), 16'(16'hFFF0 - i * 40), 0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 5'(31 - i), 16'(i * 100), 0, 0);
        // R4: release; high entries must drain before remaining low ones
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        // R8: squash one high and one low
        cyc(1, 1, 0, 5'd31, 16'h7FFF, 0, 0);
        cyc(1, 0, 0, 5'd0, 16'h0001, 0, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 1);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            cyc($urandom_range(0, 99) < 45, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                5'($urandom()), 16'($urandom()), r < 4, r >= 4 && r < 6);
        end

        // Drain and compare counters (R8, R9)
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        chk(!pf_req_valid && mq_hi.size() == 0 && mq_lo.size() == 0, "R9 drained and quiet",
            32'(pf_req_valid), 0);
        chk(cnt_issue_hi == 16'(e_iss_hi), "R8 issue hi", 32'(cnt_issue_hi), 32'(e_iss_hi));
        chk(cnt_issue_lo == 16'(e_iss_lo), "R8 issue lo", 32'(cnt_issue_lo), 32'(e_iss_lo));
        chk(cnt_squash_hi == 16'(e_sq_hi), "R8 squash hi", 32'(cnt_squash_hi), 32'(e_sq_hi));
        chk(cnt_squash_lo == 16'(e_sq_lo), "R8 squash lo", 32'(cnt_squash_lo), 32'(e_sq_lo));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule